// File: doc/BRIEF.md
# System Control Register File

This block is a bank of control and status words on a plain 32-bit register bus. The bus has a word address, a write strobe with write data, and a read strobe with registered read data. It decodes a 4 KiB byte window. The low part of the window is backed by an array of ordinary read/write words. A handful of those words take fixed non-zero values at reset, and three of them read back with two fixed status bits forced high.

One dedicated command word sits higher in the window. Software writes a code into it to ask the system for a reset or for a shutdown. The block turns an accepted code into a single-cycle request pulse for the power and reset sequencer, which lies outside this block. The command word also keeps the last value written to it, so it can be read back.

There is no handshake at the bus edge. Every strobe is accepted in the cycle it is presented. Read data appears one cycle after the read strobe and then holds until the next read.

Top module: `sysctl_regfile`

## Requirements
- R1: When `rst_n` is sampled low, every backed word clears to zero except four preset words: word 0x40 = 0x05F20121, word 0x41 = 0x00000002, word 0x42 = 0x05F30121 and word 0x43 = 0x05F40121. The command word and `bus_rdata` also clear to zero.
- R2: A write to a backed word stores `bus_wdata` at word index `bus_addr[11:2]`. A read with `bus_rd` high returns the addressed word on `bus_rdata` after the next rising edge.
- R3: A write of 1 or 2 to byte offset 0xF00 drives `sys_reset_req` high for exactly the one cycle after the accepting edge.
- R4: A write of 3 to byte offset 0xF00 drives `sys_halt_req` high for exactly that one cycle. The two request pulses are never high together.
- R5: A write of any other value to 0xF00, or any write to another offset, raises neither request.
- R6: Every write to 0xF00 stores its data, whatever the value, and a read of 0xF00 returns it.
- R7: Reads of byte offsets 0x100, 0x108 and 0x10C return the stored word ORed with 0x30000000 (bits 29 and 28). Other offsets, 0x104 among them, return the stored value unchanged.
- R8: Address bits 1:0 are ignored for both reads and writes.
- R9: Offsets at or above the backed range (0x800 by default), other than 0xF00, read as zero, and writes to them change nothing.
- R10: `bus_rdata` keeps its value in any cycle without a read strobe.
- R11: When a read and a write hit the same word in the same cycle, the read returns the value held before that write.
- R12: While `rst_n` is low, both request outputs stay low even if a request code is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_wr | input | 1 | Write strobe, accepted on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| sys_reset_req | output | 1 | One-cycle system reset request |
| sys_halt_req | output | 1 | One-cycle system shutdown request |

## Verification
The bench uses the default parameters: a 12-bit address, 512 backed words and the command word at 0xF00. With these values the backed array ends at byte 0x7FC. This puts both unbacked stretches within reach, 0x800 to 0xEFC and 0xF04 upward, so the bench can show that the command word reads back while its neighbours read zero. The same build places the four preset words and the three forced-bit offsets in one small cluster. That lets the bench check that 0x104 is left unforced, and that a stored zero at a forced offset still shows the two status bits.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;

  localparam int SC_DW = 32;

  // status bits that always read high on the forced words
  localparam logic [SC_DW-1:0] SC_FORCE_MASK = 32'h3000_0000;

  localparam int SC_NFORCE = 3;
  localparam int SC_FORCE_IDX [SC_NFORCE] = '{32'h40, 32'h42, 32'h43};

  typedef enum logic [1:0] {
    SC_CMD_NONE,
    SC_CMD_RESET,
    SC_CMD_HALT
  } sc_cmd_e;

  // reset image of one backed word
  function automatic logic [SC_DW-1:0] sc_preset(int idx);
    case (idx)
      32'h40:  return 32'h05F2_0121;
      32'h41:  return 32'h0000_0002;
      32'h42:  return 32'h05F3_0121;
      32'h43:  return 32'h05F4_0121;
      default: return '0;
    endcase
  endfunction

  // classify a value written to the command word
  function automatic sc_cmd_e sc_decode_cmd(logic [SC_DW-1:0] v);
    case (v)
      32'd1, 32'd2: return SC_CMD_RESET;
      32'd3:        return SC_CMD_HALT;
      default:      return SC_CMD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
`timescale 1ns/1ps
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int IDX_W       = 10,
  parameter int STORE_WORDS = 512,
  parameter int CMD_OFFSET  = 'hF00,
  parameter int SIW         = (STORE_WORDS > 1) ? $clog2(STORE_WORDS) : 1
) (
  input  logic [IDX_W-1:0] word_idx,
  output logic [SIW-1:0]   store_idx,
  output logic             hit_store,
  output logic             hit_cmd,
  output logic             hit_force
);

  localparam logic [IDX_W-1:0] CMD_IDX = IDX_W'(CMD_OFFSET >> 2);

  logic                 in_range;
  logic [SC_NFORCE-1:0] force_hit;

  generate
    if (STORE_WORDS >= (1 << IDX_W)) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_part
      localparam logic [IDX_W:0] LIM = (IDX_W+1)'(STORE_WORDS);
      assign in_range = ({1'b0, word_idx} < LIM);
    end
  endgenerate

  generate
    for (genvar f = 0; f < SC_NFORCE; f++) begin : g_force
      assign force_hit[f] = (word_idx == IDX_W'(SC_FORCE_IDX[f]));
    end
  endgenerate

  assign store_idx = word_idx[SIW-1:0];
  assign hit_cmd   = (word_idx == CMD_IDX);
  assign hit_store = in_range && !hit_cmd;
  assign hit_force = hit_store && (|force_hit);

endmodule

// File: rtl/sysctl_store.sv
`timescale 1ns/1ps
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int STORE_WORDS = 512,
  parameter int SIW         = (STORE_WORDS > 1) ? $clog2(STORE_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SIW-1:0]   idx,
  input  logic [SC_DW-1:0] wdata,
  output logic [SC_DW-1:0] rdata
);

  logic [SC_DW-1:0] mem [STORE_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STORE_WORDS; i++) begin
        mem[i] <= sc_preset(i);
      end
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  // combinational read of the pre-write contents
  assign rdata = mem[idx];

endmodule

// File: rtl/sysctl_cmd_ctl.sv
`timescale 1ns/1ps
module sysctl_cmd_ctl
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [SC_DW-1:0] wdata,
  output logic [SC_DW-1:0] cmd_word,
  output logic             reset_req,
  output logic             halt_req
);

  sc_cmd_e code;

  assign code = sc_decode_cmd(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_word  <= '0;
      reset_req <= 1'b0;
      halt_req  <= 1'b0;
    end else begin
      reset_req <= fire && (code == SC_CMD_RESET);
      halt_req  <= fire && (code == SC_CMD_HALT);
      if (fire) begin
        cmd_word <= wdata;
      end
    end
  end

endmodule

// File: rtl/sysctl_regfile.sv
`timescale 1ns/1ps
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int STORE_WORDS = 512,
  parameter int CMD_OFFSET  = 'hF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [SC_DW-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [SC_DW-1:0]  bus_rdata,
  output logic              sys_reset_req,
  output logic              sys_halt_req
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int SIW   = (STORE_WORDS > 1) ? $clog2(STORE_WORDS) : 1;

  logic [IDX_W-1:0] word_idx;
  logic [SIW-1:0]   store_idx;
  logic             hit_store;
  logic             hit_cmd;
  logic             hit_force;
  logic [SC_DW-1:0] store_rd;
  logic [SC_DW-1:0] cmd_word;
  logic [SC_DW-1:0] rd_sel;
  logic             addr_lsb_unused;

  // byte lanes are not supported: the two low address bits carry nothing
  assign addr_lsb_unused = ^bus_addr[1:0];
  assign word_idx        = bus_addr[ADDR_W-1:2];

  sysctl_decode #(
    .IDX_W      (IDX_W),
    .STORE_WORDS(STORE_WORDS),
    .CMD_OFFSET (CMD_OFFSET),
    .SIW        (SIW)
  ) u_dec (
    .word_idx (word_idx),
    .store_idx(store_idx),
    .hit_store(hit_store),
    .hit_cmd  (hit_cmd),
    .hit_force(hit_force)
  );

  sysctl_store #(
    .STORE_WORDS(STORE_WORDS),
    .SIW        (SIW)
  ) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (bus_wr && hit_store),
    .idx  (store_idx),
    .wdata(bus_wdata),
    .rdata(store_rd)
  );

  sysctl_cmd_ctl u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (bus_wr && hit_cmd),
    .wdata    (bus_wdata),
    .cmd_word (cmd_word),
    .reset_req(sys_reset_req),
    .halt_req (sys_halt_req)
  );

  always_comb begin
    rd_sel = '0;
    if (hit_store) begin
      rd_sel = store_rd | (hit_force ? SC_FORCE_MASK : '0);
    end else if (hit_cmd) begin
      rd_sel = cmd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_sel;
    end
  end

endmodule

// File: rtl/sysctl_regfile_chk.sv
`timescale 1ns/1ps
module sysctl_regfile_chk
  import sysctl_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int STORE_WORDS = 512,
  parameter int CMD_OFFSET  = 'hF00
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [SC_DW-1:0]  bus_wdata,
  input logic              bus_rd,
  input logic [SC_DW-1:0]  bus_rdata,
  input logic              sys_reset_req,
  input logic              sys_halt_req
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] CMD_W = IDX_W'(CMD_OFFSET >> 2);
  localparam logic [IDX_W:0]   LIM_W = (IDX_W+1)'(STORE_WORDS);

  logic [IDX_W-1:0] widx;
  logic             on_cmd;
  logic             in_hole;
  logic             rst_code;
  logic             halt_code;

  assign widx      = bus_addr[ADDR_W-1:2];
  assign on_cmd    = (widx == CMD_W);
  assign in_hole   = ({1'b0, widx} >= LIM_W) && !on_cmd;
  assign rst_code  = (bus_wdata == 32'd1) || (bus_wdata == 32'd2);
  assign halt_code = (bus_wdata == 32'd3);

  // R3
  reset_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && on_cmd && rst_code) |=> sys_reset_req);

  // R4
  halt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && on_cmd && halt_code) |=> sys_halt_req);

  // R4
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_reset_req && sys_halt_req));

  // R5
  no_stray_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && on_cmd && (rst_code || halt_code)) |=> (!sys_reset_req && !sys_halt_req));

  // R9
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && in_hole) |=> (bus_rdata == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!sys_reset_req && !sys_halt_req));

endmodule

bind sysctl_regfile sysctl_regfile_chk #(
  .ADDR_W     (ADDR_W),
  .STORE_WORDS(STORE_WORDS),
  .CMD_OFFSET (CMD_OFFSET)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .sys_reset_req(sys_reset_req),
  .sys_halt_req (sys_halt_req)
);

// File: tb/sim_sysctl_regfile.sv
`timescale 1ns/1ps
module sim_sysctl_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        sys_reset_req;
  logic        sys_halt_req;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sysctl_regfile u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .sys_reset_req(sys_reset_req),
    .sys_halt_req (sys_halt_req)
  );

  // vector: {req id, is_read, byte addr, write data, expected}
  // expected is read data for reads, {halt, reset} pulses for writes
  localparam int NV = 26;
  localparam logic [80:0] VEC [NV] = '{
    {4'd1,  1'b1, 12'h100, 32'h0,         32'h35F2_0121}, // R1 R7 preset plus forced bits
    {4'd1,  1'b1, 12'h104, 32'h0,         32'h0000_0002}, // R1 R7 unforced preset
    {4'd1,  1'b1, 12'h108, 32'h0,         32'h35F3_0121}, // R1 R7
    {4'd1,  1'b1, 12'h10C, 32'h0,         32'h35F4_0121}, // R1 R7
    {4'd1,  1'b1, 12'h000, 32'h0,         32'h0000_0000}, // R1 plain word clears
    {4'd1,  1'b1, 12'hF00, 32'h0,         32'h0000_0000}, // R1 command word clears
    {4'd2,  1'b0, 12'h010, 32'hA5A5_0F0F, 32'h0},         // R2 R5
    {4'd2,  1'b1, 12'h010, 32'h0,         32'hA5A5_0F0F}, // R2
    {4'd2,  1'b0, 12'h7FC, 32'h1234_5678, 32'h0},         // R2 top backed word
    {4'd2,  1'b1, 12'h7FC, 32'h0,         32'h1234_5678}, // R2
    {4'd7,  1'b0, 12'h100, 32'h0000_0000, 32'h0},         // R7
    {4'd7,  1'b1, 12'h100, 32'h0,         32'h3000_0000}, // R7 forced over zero
    {4'd7,  1'b0, 12'h104, 32'h0000_0000, 32'h0},         // R7
    {4'd7,  1'b1, 12'h104, 32'h0,         32'h0000_0000}, // R7 not forced
    {4'd3,  1'b0, 12'hF00, 32'h0000_0001, 32'h1},         // R3 code 1
    {4'd6,  1'b1, 12'hF00, 32'h0,         32'h0000_0001}, // R6
    {4'd3,  1'b0, 12'hF00, 32'h0000_0002, 32'h1},         // R3 code 2
    {4'd4,  1'b0, 12'hF00, 32'h0000_0003, 32'h2},         // R4 code 3
    {4'd5,  1'b0, 12'hF00, 32'h0000_0004, 32'h0},         // R5
    {4'd5,  1'b0, 12'hF00, 32'h0000_0101, 32'h0},         // R5 low bits look like 1
    {4'd6,  1'b1, 12'hF00, 32'h0,         32'h0000_0101}, // R6
    {4'd8,  1'b0, 12'h013, 32'hCAFE_0001, 32'h0},         // R8 low bits dropped
    {4'd8,  1'b1, 12'h011, 32'h0,         32'hCAFE_0001}, // R8
    {4'd9,  1'b0, 12'h900, 32'hDEAD_BEEF, 32'h0},         // R9
    {4'd9,  1'b1, 12'h900, 32'h0,         32'h0000_0000}, // R9 hole reads zero
    {4'd9,  1'b1, 12'hF04, 32'h0,         32'h0000_0000}  // R9 above command word
  };

  task automatic check(input bit ok, input int rid, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d actual %h expected %h", rid, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    d        = bus_rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual running expected done");
    finish_run();
  end

  initial begin
    logic [31:0] got;
    logic [31:0] held;

    repeat (3) @(negedge clk);
    // R12 requests low in reset
    check({sys_halt_req, sys_reset_req} == 2'b00, 12,
          {30'h0, sys_halt_req, sys_reset_req}, 32'h0);
    // R1 read data cleared
    check(bus_rdata == 32'h0, 1, bus_rdata, 32'h0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [80:0] v;
      v = VEC[k];
      if (v[76]) begin
        do_read(v[75:64], got);
        check(got == v[31:0], int'(v[80:77]), got, v[31:0]);
      end else begin
        do_write(v[75:64], v[63:32]);
        check({sys_halt_req, sys_reset_req} == v[1:0], int'(v[80:77]),
              {30'h0, sys_halt_req, sys_reset_req}, v[31:0]);
        @(negedge clk);
        // R3 R4 pulse lasts a single cycle
        check({sys_halt_req, sys_reset_req} == 2'b00, int'(v[80:77]),
              {30'h0, sys_halt_req, sys_reset_req}, 32'h0);
      end
    end

    // R10 read data holds without a read strobe
    do_read(12'h010, held);
    @(negedge clk);
    bus_addr  = 12'h7FC;
    bus_wdata = 32'h5555_AAAA;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    check(bus_rdata == held, 10, bus_rdata, held);

    // R11 read and write to one word in one cycle return the old value
    @(negedge clk);
    bus_addr  = 12'h7FC;
    bus_wdata = 32'h1111_2222;
    bus_wr    = 1'b1;
    bus_rd    = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    check(bus_rdata == 32'h5555_AAAA, 11, bus_rdata, 32'h5555_AAAA);
    do_read(12'h7FC, got);
    check(got == 32'h1111_2222, 11, got, 32'h1111_2222);

    // R12 request code written during reset raises nothing
    @(negedge clk);
    rst_n     = 1'b0;
    bus_addr  = 12'hF00;
    bus_wdata = 32'h1;
    bus_wr    = 1'b1;
    @(negedge clk);
    check({sys_halt_req, sys_reset_req} == 2'b00, 12,
          {30'h0, sys_halt_req, sys_reset_req}, 32'h0);
    bus_wdata = 32'h3;
    @(negedge clk);
    check({sys_halt_req, sys_reset_req} == 2'b00, 12,
          {30'h0, sys_halt_req, sys_reset_req}, 32'h0);
    bus_wr = 1'b0;
    rst_n  = 1'b1;

    // R1 contents restored by the second reset
    do_read(12'h010, got);
    check(got == 32'h0, 1, got, 32'h0);
    do_read(12'h100, got);
    check(got == 32'h35F2_0121, 1, got, 32'h35F2_0121);
    do_read(12'h104, got);
    check(got == 32'h0000_0002, 1, got, 32'h0000_0002);
    do_read(12'hF00, got);
    check(got == 32'h0, 1, got, 32'h0);

    finish_run();
  end

endmodule